// File: doc/BRIEF.md
# Hot-Spot Activity Migration Controller

This block supervises two identical copies of a hot execution unit. Only one copy does work at any time. The controller hands the work from the running copy to the resting copy so that heat is spread across the die. A handover can be triggered in two ways. In period mode it fires after the running copy has been in service for a programmed number of cycles. In sensor mode it fires when the running copy's temperature reading climbs above that copy's threshold while the resting copy is cool enough to take over.

Every handover follows the same order:
1. Stall the upstream front end.
2. Wait for the running copy's pipeline to report empty.
3. Power up the resting copy.
4. Stream the architectural state across one word per cycle.
5. Flip the active index, power down the old copy, and release the stall.

The state stream is valid/ready. `copy_idx` is offered with `copy_valid`, a word moves only in a cycle where `copy_ready` is also high, and while `copy_ready` is low the index stays unchanged. Control and status pins are plain levels or one-cycle pulses.

Top module: `migration_ctrl`

## Requirements
- R1: After reset, copy 0 is active: `active_idx`=0, `pwr_en`=2'b01, `stall_req`=0 and `mig_count`=0.
- R2: Whenever `stall_req` is low, exactly one bit of `pwr_en` is set. It is bit `active_idx` (bit 0 = copy 0, bit 1 = copy 1).
- R3: In period mode (`mode_sensor`=0), `stall_req` stays low for exactly `period_cfg` cycles between the end of one migration and the start of the next. A `period_cfg` of 0 never starts a migration.
- R4: `stall_req` rises in the cycle after the trigger. It stays high through the `copy_done` pulse and falls in the cycle after that pulse.
- R5: No state word is offered before `pipe_empty` has been seen high while stalled. `copy_start` is a one-cycle pulse in the first copy cycle.
- R6: Both bits of `pwr_en` are high from `copy_start` through `copy_done`. When the stall falls, `active_idx` has toggled and only the new copy is powered.
- R7: The copy stream offers indices 0 to `words_cfg`-1 in order, one per accepted handshake, and holds the index while `copy_ready` is low. `copy_done` pulses in the cycle after the last accepted word. A `words_cfg` of 0 moves no words and pulses `copy_done` in the first copy cycle.
- R8: In sensor mode, a migration starts only when the active copy's temperature is strictly above its threshold and the idle copy's temperature is strictly below its own threshold.
- R9: In sensor mode, no migration starts during the first `dwell_cfg` running cycles after a migration. When the temperature condition holds throughout, the stall-free gap is `dwell_cfg`+1 cycles.
- R10: `mig_count` increments by one per completed migration and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sensor | input | 1 | 0 = period trigger, 1 = temperature trigger |
| period_cfg | input | CNT_W | Running cycles per copy in period mode (0 = off) |
| dwell_cfg | input | CNT_W | Minimum running cycles after a migration in sensor mode |
| temp0 | input | TEMP_W | Temperature reading of copy 0 |
| temp1 | input | TEMP_W | Temperature reading of copy 1 |
| thresh0 | input | TEMP_W | Threshold for copy 0 |
| thresh1 | input | TEMP_W | Threshold for copy 1 |
| words_cfg | input | WIDX_W | Number of state words to transfer |
| stall_req | output | 1 | Stall request to the front end |
| pipe_empty | input | 1 | Active copy has no in-flight work |
| copy_start | output | 1 | One-cycle pulse at the start of the state copy |
| copy_valid | output | 1 | A state word index is offered |
| copy_ready | input | 1 | The copy datapath accepts the offered word |
| copy_idx | output | WIDX_W | Index of the offered state word |
| copy_done | output | 1 | One-cycle pulse after the last word |
| pwr_en | output | 2 | Active-power enable per copy |
| active_idx | output | 1 | Copy currently doing the work |
| mig_count | output | MCNT_W | Saturating count of completed migrations |

## Verification
The hardest situation to reach from the ports is the sensor-mode dwell window. It needs a migration to have just finished, with the temperatures already favouring the next one, so that only the dwell counter holds the trigger back. The bench drives each copy's temperature from `active_idx` on every cycle: the running copy always reads hot and the resting copy always reads cool. Migrations then chain back to back, and the measured stall-free gap shows the dwell length directly for several dwell values. Saturation of the migration counter follows from the same chained runs.

// File: rtl/mig_pkg.sv
package mig_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_COPY  = 2'd2
  } mig_state_t;
endpackage

// File: rtl/mig_trigger.sv
module mig_trigger #(
  parameter int CNT_W  = 18,
  parameter int TEMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              restart,
  input  logic              mode_sensor,
  input  logic [CNT_W-1:0]  period_cfg,
  input  logic [CNT_W-1:0]  dwell_cfg,
  input  logic [TEMP_W-1:0] temp_act,
  input  logic [TEMP_W-1:0] thr_act,
  input  logic [TEMP_W-1:0] temp_idle,
  input  logic [TEMP_W-1:0] thr_idle,
  output logic              fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] run_cnt;
  logic             period_hit;
  logic             sensor_hit;

  // cycles the active copy has spent running since the last handover
  always_ff @(posedge clk) begin
    if (!rst_n || restart) run_cnt <= '0;
    else if (running && run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
  end

  always_comb begin
    period_hit = (period_cfg != '0) && (run_cnt >= period_cfg - 1'b1);
    sensor_hit = (run_cnt >= dwell_cfg) && (temp_act > thr_act) && (temp_idle < thr_idle);
    fire       = running && (mode_sensor ? sensor_hit : period_hit);
  end
endmodule

// File: rtl/mig_copy_seq.sv
module mig_copy_seq #(
  parameter int WIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WIDX_W-1:0] words_cfg,
  input  logic              copy_ready,
  output logic              copy_valid,
  output logic [WIDX_W-1:0] copy_idx,
  output logic              copy_done
);
  logic [WIDX_W-1:0] words_q;
  logic              last_word;

  assign last_word = (copy_idx == words_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      copy_valid <= 1'b0;
      copy_idx   <= '0;
      copy_done  <= 1'b0;
      words_q    <= '0;
    end else begin
      copy_done <= 1'b0;
      if (start) begin
        words_q  <= words_cfg;
        copy_idx <= '0;
        if (words_cfg == '0) copy_done  <= 1'b1;
        else                 copy_valid <= 1'b1;
      end else if (copy_valid && copy_ready) begin
        if (last_word) begin
          copy_valid <= 1'b0;
          copy_done  <= 1'b1;
        end else begin
          copy_idx <= copy_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mig_sat_cnt.sv
module mig_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else if (inc && value != TOP) value <= value + 1'b1;
  end
endmodule

// File: rtl/migration_ctrl.sv
module migration_ctrl #(
  parameter int CNT_W  = 18,
  parameter int TEMP_W = 8,
  parameter int WIDX_W = 6,
  parameter int MCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sensor,
  input  logic [CNT_W-1:0]  period_cfg,
  input  logic [CNT_W-1:0]  dwell_cfg,
  input  logic [TEMP_W-1:0] temp0,
  input  logic [TEMP_W-1:0] temp1,
  input  logic [TEMP_W-1:0] thresh0,
  input  logic [TEMP_W-1:0] thresh1,
  input  logic [WIDX_W-1:0] words_cfg,
  output logic              stall_req,
  input  logic              pipe_empty,
  output logic              copy_start,
  output logic              copy_valid,
  input  logic              copy_ready,
  output logic [WIDX_W-1:0] copy_idx,
  output logic              copy_done,
  output logic [1:0]        pwr_en,
  output logic              active_idx,
  output logic [MCNT_W-1:0] mig_count
);
  import mig_pkg::*;

  mig_state_t        st;
  logic              active_q;
  logic [1:0]        pwr_q;
  logic              start_q;
  logic              fire;
  logic              start_now;
  logic              finish_now;
  logic [TEMP_W-1:0] temp_act, temp_idle, thr_act, thr_idle;

  // per-copy readings routed by the active index
  always_comb begin
    temp_act   = active_q ? temp1   : temp0;
    temp_idle  = active_q ? temp0   : temp1;
    thr_act    = active_q ? thresh1 : thresh0;
    thr_idle   = active_q ? thresh0 : thresh1;
    start_now  = (st == ST_DRAIN) && pipe_empty;
    finish_now = (st == ST_COPY) && copy_done;
  end

  mig_trigger #(.CNT_W(CNT_W), .TEMP_W(TEMP_W)) u_trig (
    .clk(clk), .rst_n(rst_n),
    .running(st == ST_RUN), .restart(finish_now),
    .mode_sensor(mode_sensor), .period_cfg(period_cfg), .dwell_cfg(dwell_cfg),
    .temp_act(temp_act), .thr_act(thr_act),
    .temp_idle(temp_idle), .thr_idle(thr_idle),
    .fire(fire)
  );

  mig_copy_seq #(.WIDX_W(WIDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_now), .words_cfg(words_cfg),
    .copy_ready(copy_ready), .copy_valid(copy_valid),
    .copy_idx(copy_idx), .copy_done(copy_done)
  );

  mig_sat_cnt #(.W(MCNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(finish_now), .value(mig_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      active_q <= 1'b0;
      pwr_q    <= 2'b01;
      start_q  <= 1'b0;
    end else begin
      start_q <= start_now;
      unique case (st)
        ST_RUN:   if (fire) st <= ST_DRAIN;
        ST_DRAIN: if (pipe_empty) begin
          st    <= ST_COPY;
          pwr_q <= 2'b11;            // target up before any word moves
        end
        ST_COPY:  if (copy_done) begin
          st       <= ST_RUN;
          active_q <= ~active_q;
          pwr_q    <= active_q ? 2'b01 : 2'b10;  // source down after copy
        end
        default:  st <= ST_RUN;
      endcase
    end
  end

  assign stall_req  = (st != ST_RUN);
  assign copy_start = start_q;
  assign pwr_en     = pwr_q;
  assign active_idx = active_q;
endmodule

// File: rtl/mig_ctrl_checker.sv
module mig_ctrl_checker #(
  parameter int WIDX_W = 6,
  parameter int MCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_req,
  input logic              pipe_empty,
  input logic              copy_start,
  input logic              copy_valid,
  input logic              copy_ready,
  input logic [WIDX_W-1:0] copy_idx,
  input logic              copy_done,
  input logic [1:0]        pwr_en,
  input logic              active_idx,
  input logic [MCNT_W-1:0] mig_count
);
  assert_one_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_req |-> ($countones(pwr_en) == 1 && pwr_en[active_idx]));

  assert_stall_until_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall_req) |-> $past(copy_done));

  assert_start_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |-> (stall_req && $past(pipe_empty)));

  assert_both_powered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_valid |-> pwr_en == 2'b11);

  assert_idx_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_valid && !copy_ready) |=> (copy_valid && $stable(copy_idx)));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mig_count) |-> mig_count == $past(mig_count) + 1'b1);
endmodule

bind migration_ctrl mig_ctrl_checker #(.WIDX_W(WIDX_W), .MCNT_W(MCNT_W)) u_chk (.*);

// File: tb/sim_migration_ctrl.sv
module sim_migration_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8, TEMP_W = 8, WIDX_W = 3, MCNT_W = 3;
  localparam int CNT_TOP = (1 << MCNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sensor = 1'b0;
  logic [CNT_W-1:0] period_cfg = '0, dwell_cfg = '0;
  logic [TEMP_W-1:0] temp0 = 8'd50, temp1 = 8'd50, thresh0 = 8'd100, thresh1 = 8'd100;
  logic [WIDX_W-1:0] words_cfg = 3'd4;
  logic stall_req, pipe_empty = 1'b0, copy_start, copy_valid, copy_ready = 1'b1, copy_done;
  logic [WIDX_W-1:0] copy_idx;
  logic [1:0] pwr_en;
  logic active_idx;
  logic [MCNT_W-1:0] mig_count;

  int checks = 0, failures = 0, migrations = 0;
  int drain_lat = 2;
  bit ready_all = 1'b0, temp_auto = 1'b0, mon_on = 1'b0;

  migration_ctrl #(.CNT_W(CNT_W), .TEMP_W(TEMP_W), .WIDX_W(WIDX_W), .MCNT_W(MCNT_W)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // environment: drain latency, ready pattern, temperature model
  initial begin
    int dcnt = 0, cyc = 0;
    forever begin
      @(negedge clk);
      dcnt = stall_req ? dcnt + 1 : 0;
      pipe_empty = stall_req && (dcnt > drain_lat);
      copy_ready = ready_all || (cyc % 3 != 1);
      cyc++;
      if (temp_auto) begin
        temp0 = active_idx ? 8'd50 : 8'd120;
        temp1 = active_idx ? 8'd120 : 8'd50;
      end
    end
  end

  // monitor of handover sequences
  initial begin
    bit prev_stall = 1'b0, prev_done = 1'b0, prev_act = 1'b0, empty_seen = 1'b0;
    int prev_cnt = 0, exp_idx = 0, beats = 0, words_at_start = 0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (copy_start) begin
          check(pwr_en == 2'b11, "R6 target powered at copy_start", int'(pwr_en), 3);
          check(empty_seen, "R5 copy after drain", int'(empty_seen), 1);
          exp_idx = 0; beats = 0; words_at_start = int'(words_cfg);
        end
        if (copy_valid && copy_ready) begin
          check(int'(copy_idx) == exp_idx, "R7 word index order", int'(copy_idx), exp_idx);
          exp_idx++; beats++;
        end
        if (copy_done) begin
          check(stall_req, "R4 stall held at copy_done", int'(stall_req), 1);
          check(beats == words_at_start, "R7 word count", beats, words_at_start);
        end
        if (stall_req && pipe_empty) empty_seen = 1'b1;
        if (prev_stall && !stall_req) begin
          migrations++;
          check(prev_done, "R4 stall falls after done", int'(prev_done), 1);
          check(active_idx == !prev_act, "R6 active toggled", int'(active_idx), int'(!prev_act));
          check(pwr_en == (2'b01 << active_idx), "R6 source powered down", int'(pwr_en), 1 << active_idx);
          check(int'(mig_count) == ((prev_cnt + 1 > CNT_TOP) ? CNT_TOP : prev_cnt + 1),
                "R10 count", int'(mig_count), (prev_cnt + 1 > CNT_TOP) ? CNT_TOP : prev_cnt + 1);
          empty_seen = 1'b0;
        end
        if (!stall_req) begin
          if (pwr_en != (2'b01 << active_idx))
            check(1'b0, "R2 single enable", int'(pwr_en), 1 << active_idx);
          prev_act = active_idx; prev_cnt = int'(mig_count);
        end
        prev_stall = stall_req; prev_done = copy_done;
      end
    end
  end

  task automatic wait_stall(input bit v, input int maxc, input string req);
    int n = 0;
    while (stall_req != v && n < maxc) begin @(negedge clk); n++; end
    check(stall_req == v, req, int'(stall_req), int'(v));
  endtask

  // called at a negedge with stall low; returns the stall-free run length
  task automatic gap(output int n);
    n = 1;
    forever begin
      @(negedge clk);
      if (stall_req || n > 400) break;
      n++;
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (stall_req) seen++; end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(active_idx == 1'b0, "R1 reset active", int'(active_idx), 0);
    check(pwr_en == 2'b01, "R1 reset power", int'(pwr_en), 1);
    check(!stall_req, "R1 reset stall", int'(stall_req), 0);
    check(mig_count == '0, "R1 reset count", int'(mig_count), 0);
    mon_on = 1'b1;
    quiet(40, "R3 period zero idle");

    // period mode sweep over period, drain latency and word count
    for (int p = 1; p <= 6; p++) begin
      period_cfg = CNT_W'(p);
      drain_lat = p % 3;
      words_cfg = WIDX_W'((p == 4) ? 0 : p + 1);
      ready_all = (p % 2 == 0);
      wait_stall(1'b1, 400, "R3 migration started");
      wait_stall(1'b0, 400, "R4 migration finished");
      gap(n);
      check(n == p, "R3 period gap", n, p);
    end
    period_cfg = '0;
    wait_stall(1'b0, 400, "R4 migration finished");
    quiet(50, "R3 period zero stops migration");

    // sensor mode, manual temperatures
    mode_sensor = 1'b1; dwell_cfg = '0;
    if (active_idx) begin temp1 = 8'd60; temp0 = 8'd40; end
    else            begin temp0 = 8'd60; temp1 = 8'd40; end
    quiet(30, "R8 active below threshold");
    if (active_idx) begin temp1 = 8'd120; temp0 = 8'd100; end
    else            begin temp0 = 8'd120; temp1 = 8'd100; end
    quiet(30, "R8 idle not below threshold");
    if (active_idx) temp0 = 8'd99; else temp1 = 8'd99;
    wait_stall(1'b1, 5, "R8 sensor trigger");

    // dwell sweep with chained migrations
    temp_auto = 1'b1;
    for (int d = 0; d <= 6; d += 3) begin
      dwell_cfg = CNT_W'(d);
      wait_stall(1'b0, 400, "R4 migration finished");
      gap(n);
      check(n == d + 1, "R9 dwell gap", n, d + 1);
    end
    wait_stall(1'b0, 400, "R4 migration finished");
    check(migrations > CNT_TOP, "R10 enough migrations", migrations, CNT_TOP + 1);
    check(int'(mig_count) == CNT_TOP, "R10 saturated", int'(mig_count), CNT_TOP);
    finish_run();
  end
endmodule